// File: doc/BRIEF.md
# Serial DMA request encoder

This block gathers eight legacy DMA request lines and sends them, one clock slot at a time, to a primary bus arbiter over a single active-low pin. The pin and the request inputs are timed by the PCI clock (nominally 33 MHz). While no request is pending, the pin rests high. When a request appears, the block sends a frame. The frame opens with a one-clock low start marker. It then carries eight slots in channel order 0 to 7. After the frame, the pin stays low for as long as the same set of requests remains asserted.

The request inputs may be asynchronous, so they pass through a two-flop synchronizer. The block takes a snapshot of the synchronized set when it sends the start marker, and the frame carries that snapshot. If the set changes, the block releases the pin for one clock and then sends a new frame. When every request has dropped, the pin returns to idle. Channel 4 is the cascade channel. Its slot is always low, and it never starts a frame or holds one by itself.

Top module: `dma_req_serializer`

## Requirements
- R1: A synchronous active-high reset puts the pin high on the first clock edge with reset asserted. The pin stays high afterwards until a new frame begins.
- R2: When no request line other than channel 4 is asserted, the pin stays high. A request on channel 4 alone never starts a frame.
- R3: A change on the request inputs reaches the pin on the third rising clock edge after it is applied. Two edges are spent in the synchronizer and one in the encoder.
- R4: A frame begins with the pin low for exactly one clock, the start marker.
- R5: The eight clocks after the start marker carry one slot each, in channel order 0 to 7. In each slot the pin level equals that channel's request (1 = pin high).
- R6: The slot for channel 4 is always driven low, whatever its input.
- R7: The frame carries the request set captured at the start marker. Input changes during the eight slots do not alter the slots.
- R8: After the eighth slot, the pin stays low while the synchronized request set equals the captured set.
- R9: When all requests drop, the pin goes high and stays high.
- R10: If the request set changes to a different non-empty set at or after the end of a frame, the pin goes high for exactly one clock. A new frame carrying the new set then follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock |
| rst | input | 1 | Synchronous reset, active high |
| dreq_in | input | 8 | Legacy DMA request lines, active high, bit n is channel n |
| req_n | output | 1 | Serial encoded request pin, active low |

## Verification
The assertions assume that reset is held for at least one edge before the first request. They also assume that the request inputs only change away from the rising edge, so that the synchronizer delivers each change whole and the slot timing can be counted. The bench drives every input on the falling edge and sweeps all 256 request patterns from idle. Each pattern is held long enough to reach the hold phase, and then cleared. Separate runs change the set during the hold phase, change it in the middle of the slots, and assert reset during a frame.

// File: rtl/dma_req_serializer.sv
module dma_req_serializer #(
  parameter int CHANNELS  = 8,
  parameter int SILENT_CH = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CHANNELS-1:0] dreq_in,
  output logic                req_n
);
  localparam int IW = $clog2(CHANNELS);
  localparam logic [CHANNELS-1:0] KEEP = ~(CHANNELS'(1) << SILENT_CH);
  localparam logic [IW-1:0] LAST = IW'(CHANNELS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_BITS, S_HOLD, S_GAP} st_t;

  st_t st, after_frame;
  logic [CHANNELS-1:0] s1, s2, cap, eff;
  logic [IW-1:0] idx;

  assign eff = s2 & KEEP;
  assign after_frame = (eff == '0) ? S_IDLE : (eff != cap) ? S_GAP : S_HOLD;
  assign req_n = (st == S_IDLE || st == S_GAP) ? 1'b1 :
                 (st == S_BITS) ? cap[idx] : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1  <= '0;
      s2  <= '0;
      cap <= '0;
      idx <= '0;
      st  <= S_IDLE;
    end else begin
      s1 <= dreq_in;
      s2 <= s1;
      case (st)
        S_IDLE, S_GAP: begin
          if (|eff) begin
            st  <= S_START;
            cap <= eff;
          end else begin
            st <= S_IDLE;
          end
        end
        S_START: begin
          st  <= S_BITS;
          idx <= '0;
        end
        S_BITS: begin
          idx <= idx + 1'b1;
          if (idx == LAST) st <= after_frame;
        end
        S_HOLD:  st <= after_frame;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> req_n);

  p_start_one_clk_r4: assert property (@(posedge clk) disable iff (rst)
    (st == S_START) |-> (!req_n ##1 (st == S_BITS && idx == '0)));

  p_eight_slots_r5: assert property (@(posedge clk) disable iff (rst)
    (st == S_BITS && idx == LAST) |=> (st != S_BITS));

  p_slot_silent_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_BITS && idx == IW'(SILENT_CH)) |-> !req_n);

  p_capture_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (st == S_BITS) |=> $stable(cap));

  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    (st == S_HOLD && eff == '0) |=> req_n);

  p_gap_r10: assert property (@(posedge clk) disable iff (rst)
    (st == S_HOLD && eff != cap && eff != '0) |=> (req_n ##1 !req_n));
endmodule

// File: tb/dma_req_serializer_test.sv
module dma_req_serializer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] dreq_in = '0;
  logic req_n;
  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  dma_req_serializer uut (.clk(clk), .rst(rst), .dreq_in(dreq_in), .req_n(req_n));

  always #5 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (req_n !== exp) begin
      fails++;
      $display("FAIL %s: req_n=%b expected %b at cycle %0d", tag, req_n, exp, cycles);
    end
  endtask

  function automatic logic slot(input logic [7:0] p, input int k);
    return (k == 4) ? 1'b0 : p[k];
  endfunction

  task automatic frame_bits(input logic [7:0] p, input string tag);
    for (int k = 0; k < 8; k++) begin
      tick();
      chk(slot(p, k), tag);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected <= 100000", cycles);
      finish_run();
    end
  end

  initial begin
    tick();
    tick();
    chk(1'b1, "R1 pin high in reset");
    rst = 1'b0;
    tick();
    chk(1'b1, "R1 pin high after reset");

    for (int p = 0; p < 256; p++) begin
      dreq_in = 8'(p);
      if ((p & 8'hEF) == 0) begin
        for (int c = 0; c < 6; c++) begin
          tick();
          chk(1'b1, "R2 idle with no effective request");
        end
        dreq_in = '0;
        tick(); tick(); tick();
      end else begin
        tick(); chk(1'b1, "R3 latency edge 1");
        tick(); chk(1'b1, "R3 latency edge 2");
        tick(); chk(1'b0, "R4 start marker");
        frame_bits(8'(p), "R5 R6 slot value");
        tick(); chk(1'b0, "R8 hold");
        tick(); chk(1'b0, "R8 hold");
        dreq_in = '0;
        tick(); chk(1'b0, "R8 hold until drop seen");
        tick(); chk(1'b0, "R8 hold until drop seen");
        tick(); chk(1'b1, "R9 release");
        tick(); chk(1'b1, "R9 stays released");
      end
    end

    dreq_in = 8'h01;
    tick(); tick(); tick();
    chk(1'b0, "R4 start");
    frame_bits(8'h01, "R5 first frame");
    tick(); chk(1'b0, "R8 hold");
    dreq_in = 8'h82;
    tick(); chk(1'b0, "R10 hold before change seen");
    tick(); chk(1'b0, "R10 hold before change seen");
    tick(); chk(1'b1, "R10 gap clock");
    tick(); chk(1'b0, "R10 new start marker");
    frame_bits(8'h82, "R10 new frame");
    tick(); chk(1'b0, "R8 hold after new frame");
    dreq_in = '0;
    tick(); tick(); tick();
    chk(1'b1, "R9 release");

    dreq_in = 8'h0F;
    tick(); tick(); tick();
    chk(1'b0, "R4 start");
    tick(); chk(1'b1, "R7 slot 0");
    tick(); chk(1'b1, "R7 slot 1");
    dreq_in = 8'hF0;
    for (int k = 2; k < 8; k++) begin
      tick();
      chk(slot(8'h0F, k), "R7 slot unchanged by input");
    end
    tick(); chk(1'b1, "R10 gap after frame");
    tick(); chk(1'b0, "R10 start marker");
    frame_bits(8'hE0, "R6 R10 new frame slots");
    tick(); chk(1'b0, "R8 hold");

    dreq_in = 8'hFF;
    tick(); tick(); tick(); tick();
    rst = 1'b1;
    tick(); chk(1'b1, "R1 reset mid frame");
    dreq_in = '0;
    rst = 1'b0;
    for (int c = 0; c < 5; c++) begin
      tick();
      chk(1'b1, "R1 idle after reset");
    end

    finish_run();
  end
endmodule